// File: doc/BRIEF.md
# Bidirectional Cascaded Column Data Loader

This block is the digital front end of a display column driver. Each clock it takes one group of 8-bit gray-scale codes from a serial-to-parallel stage and writes them into per-channel load registers. Loading starts when the active start pin is sampled high. The block then walks through the channel groups in one of two directions, chosen by a single direction input. After the last group it sends a one-clock start pulse out of the other start pin, so the next chip in the cascade can continue the line.

A strobe input separates the line into two phases. On its rising edge the whole load-register array is copied into a hold latch that feeds the converters. On its falling edge the held codes appear on the channel outputs. While the outputs show one line, the load registers can already take the next one.

Top module: `colLoader`

## Requirements
- R1: After reset every channel output code is zero and the outgoing start pin is low.
- R2: With `dirRight` = 1, `startR` is the start input and `startL` is the output. Lane j of the k-th group after start (lane j is `dataIn[8j+7:8j]`, k counted from 0) goes to channel k*GROUP+j. Channel c occupies `chanOut[8c+7:8c]`.
- R3: With `dirRight` = 0, `startL` is the start input and `startR` is the output. Lane j of the k-th group goes to channel NUM_CH-1-k*GROUP-j.
- R4: The active start input is sampled at a rising clock edge while the block is idle. The NUM_CH/GROUP groups are then captured on the next NUM_CH/GROUP clock edges.
- R5: The outgoing start pin is high for exactly the one clock cycle that follows the edge loading the final group, and low at all other times.
- R6: Data words are ignored while idle, including after a complete fill, until a new start is sampled. A start seen while loading is ignored.
- R7: The first clock edge that samples the strobe high copies all load registers into the hold latch. The channel outputs do not change at that edge.
- R8: The first clock edge that samples the strobe low after it was high drives the held codes onto the channel outputs. The outputs change at no other time.
- R9: A strobe rise sampled on the same edge that loads a group captures the load registers as they were before that group was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirRight | input | 1 | Fill direction and start pin roles |
| startR | inout | 1 | Start input when dirRight=1, cascade output otherwise |
| startL | inout | 1 | Start input when dirRight=0, cascade output otherwise |
| dataIn | input | GROUP*8 | One group of gray-scale codes, lane j at bits 8j+7:8j |
| strobe | input | 1 | Latch strobe: rise latches, fall drives outputs |
| chanOut | output | NUM_CH*8 | Channel codes driven toward the converters |

## Verification
The strobe rise and the load of a channel group can land on the same clock edge. The bench provokes this by raising the strobe together with the final group of a frame, so the hold latch copies the registers while the last group is being written. After the following strobe fall, the expected output is the load-register image taken before the final group. Those channels therefore show the previous line's codes, and every other channel shows the new ones.

// File: rtl/colLoadPkg.sv
package colLoadPkg;
  typedef struct packed {
    logic loadEn;     // a group is written this cycle
    logic reverse;    // fill from the top channel downward
    logic latchHold;  // copy load registers into hold latch
    logic driveOut;   // copy hold latch onto channel outputs
  } ctlStrobes_t;
endpackage

// File: rtl/colCtrl.sv
module colCtrl
  import colLoadPkg::*;
#(
  parameter int NUM_GROUPS = 80,
  parameter int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirRight,
  input  logic          startIn,
  input  logic          strobe,
  output ctlStrobes_t   ctl,
  output logic [GW-1:0] grpIdx,
  output logic          passOut
);
  localparam logic [GW-1:0] LAST = GW'(NUM_GROUPS - 1);

  logic busy;
  logic dirLat;
  logic strbPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      grpIdx   <= '0;
      dirLat   <= 1'b1;
      passOut  <= 1'b0;
      strbPrev <= 1'b0;
    end else begin
      strbPrev <= strobe;
      passOut  <= 1'b0;
      if (!busy) begin
        if (startIn) begin
          busy   <= 1'b1;
          grpIdx <= '0;
          dirLat <= dirRight;
        end
      end else if (grpIdx == LAST) begin
        busy    <= 1'b0;
        passOut <= 1'b1;
      end else begin
        grpIdx <= grpIdx + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.loadEn    = busy;
    ctl.reverse   = !dirLat;
    ctl.latchHold = strobe && !strbPrev;
    ctl.driveOut  = !strobe && strbPrev;
  end
endmodule

// File: rtl/colData.sv
module colData
  import colLoadPkg::*;
#(
  parameter int NUM_CH = 480,
  parameter int GROUP  = 6,
  parameter int WORD   = 8,
  parameter int GW     = 7,
  localparam int FLAT  = NUM_CH * WORD
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [GW-1:0]     grpIdx,
  input  logic [GROUP*WORD-1:0] dataIn,
  output logic [FLAT-1:0]   loadFlat,
  output logic [FLAT-1:0]   holdFlat,
  output logic [FLAT-1:0]   chanOut
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int FG = c / GROUP;
    localparam int FL = c % GROUP;
    localparam int RG = (NUM_CH - 1 - c) / GROUP;
    localparam int RL = (NUM_CH - 1 - c) % GROUP;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loadFlat[c*WORD +: WORD] <= '0;
        holdFlat[c*WORD +: WORD] <= '0;
        chanOut[c*WORD +: WORD]  <= '0;
      end else begin
        if (ctl.loadEn) begin
          if (!ctl.reverse && grpIdx == GW'(FG))
            loadFlat[c*WORD +: WORD] <= dataIn[FL*WORD +: WORD];
          else if (ctl.reverse && grpIdx == GW'(RG))
            loadFlat[c*WORD +: WORD] <= dataIn[RL*WORD +: WORD];
        end
        if (ctl.latchHold)
          holdFlat[c*WORD +: WORD] <= loadFlat[c*WORD +: WORD];
        if (ctl.driveOut)
          chanOut[c*WORD +: WORD] <= holdFlat[c*WORD +: WORD];
      end
    end
  end
endmodule

// File: rtl/colLoader.sv
module colLoader
  import colLoadPkg::*;
#(
  parameter int NUM_CH = 480,
  parameter int GROUP  = 6,
  localparam int WORD  = 8,
  localparam int NUM_GROUPS = NUM_CH / GROUP,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int FLAT = NUM_CH * WORD
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dirRight,
  inout  wire                   startR,
  inout  wire                   startL,
  input  logic [GROUP*WORD-1:0] dataIn,
  input  logic                  strobe,
  output logic [FLAT-1:0]       chanOut
);
  ctlStrobes_t     ctl;
  logic [GW-1:0]   grpIdx;
  logic            passOut;
  logic            startIn;
  logic [FLAT-1:0] loadFlat;
  logic [FLAT-1:0] holdFlat;

  assign startR  = dirRight ? 1'bz : passOut;
  assign startL  = dirRight ? passOut : 1'bz;
  assign startIn = dirRight ? startR : startL;

  colCtrl #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) uCtrl (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .startIn(startIn),
    .strobe(strobe), .ctl(ctl), .grpIdx(grpIdx), .passOut(passOut)
  );

  colData #(.NUM_CH(NUM_CH), .GROUP(GROUP), .WORD(WORD), .GW(GW)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .grpIdx(grpIdx), .dataIn(dataIn),
    .loadFlat(loadFlat), .holdFlat(holdFlat), .chanOut(chanOut)
  );
endmodule

// File: rtl/colLoaderChk.sv
module colLoaderChk
  import colLoadPkg::*;
#(
  parameter int GW = 4,
  parameter int NUM_GROUPS = 6,
  parameter int FLAT = 192
) (
  input logic            clk,
  input logic            rstN,
  input logic            strobe,
  input ctlStrobes_t     ctl,
  input logic [GW-1:0]   grpIdx,
  input logic            passOut,
  input logic [FLAT-1:0] loadFlat,
  input logic [FLAT-1:0] holdFlat,
  input logic [FLAT-1:0] chanOut
);
  localparam logic [GW-1:0] LAST = GW'(NUM_GROUPS - 1);

  // R5: cascade pulse lasts one cycle
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    passOut |=> !passOut);

  // R5: pulse only follows the load of the final group
  a_r5_pulse_after_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(passOut) |-> ($past(ctl.loadEn) && $past(grpIdx) == LAST));

  // R6: load registers stay put while idle
  a_r6_idle_no_load: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadEn |=> $stable(loadFlat));

  // R7: hold latch only changes on a strobe rise
  a_r7_hold_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(strobe) |=> $stable(holdFlat));

  // R8: outputs only change on a strobe fall
  a_r8_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(strobe) |=> $stable(chanOut));
endmodule

bind colLoader colLoaderChk #(.GW(GW), .NUM_GROUPS(NUM_GROUPS), .FLAT(FLAT)) uChk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .ctl(ctl), .grpIdx(grpIdx),
  .passOut(passOut), .loadFlat(loadFlat), .holdFlat(holdFlat), .chanOut(chanOut)
);

// File: tb/colLoader_test.sv
module colLoader_test;
  localparam int NCH = 24;
  localparam int GP  = 4;
  localparam int NG  = NCH / GP;
  localparam int FL  = NCH * 8;

  logic clk = 0;
  logic rstN = 0;
  logic dirRight = 1;
  logic [GP*8-1:0] dataIn = '0;
  logic strobe = 0;
  logic [FL-1:0] chanOut;
  logic bR = 0, bL = 0;
  wire startR, startL;

  assign startR = dirRight ? bR : 1'bz;
  assign startL = dirRight ? 1'bz : bL;

  colLoader #(.NUM_CH(NCH), .GROUP(GP)) uut (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .startR(startR),
    .startL(startL), .dataIn(dataIn), .strobe(strobe), .chanOut(chanOut)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [7:0] expReg [NCH];
  logic [7:0] expHold [NCH];
  logic [7:0] expOut [NCH];

  function automatic logic [FL-1:0] pack(input logic [7:0] a [NCH]);
    logic [FL-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*8 +: 8] = a[c];
    return v;
  endfunction

  function automatic int chanOf(input bit dir, input int g, input int j);
    return dir ? g*GP + j : NCH - 1 - g*GP - j;
  endfunction

  task automatic check(input bit ok, input string req, input logic [FL-1:0] act,
                       input logic [FL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic outPin();
    return dirRight ? startL : startR;
  endfunction

  task automatic setStart(input logic v);
    if (dirRight) bR = v; else bL = v;
  endtask

  // One frame. strobeAtLast raises the strobe with the final group (R9).
  // restartAt >= 0 re-asserts start during that group (ignored, R6).
  task automatic frame(input bit dir, input bit strobeAtLast, input int restartAt);
    @(negedge clk);
    dirRight = dir;
    setStart(1);
    dataIn = $urandom;
    @(negedge clk);
    setStart(0);
    for (int g = 0; g < NG; g++) begin
      check({31'b0, outPin()} == 0, dir ? "R5 pulse early (R2)" : "R5 pulse early (R3)",
            FL'(outPin()), '0);
      dataIn = $urandom;
      if (g == restartAt) setStart(1);
      if (strobeAtLast && g == NG-1) begin
        strobe = 1;
        expHold = expReg;
      end
      for (int j = 0; j < GP; j++) expReg[chanOf(dir, g, j)] = dataIn[j*8 +: 8];
      @(negedge clk);
      setStart(0);
    end
    check(outPin() == 1'b1, "R5 pulse after last group", FL'(outPin()), FL'(1));
    dataIn = $urandom;
    @(negedge clk);
    check(outPin() == 1'b0, "R5 pulse one cycle", FL'(outPin()), '0);
  endtask

  task automatic latchAndShow(input bit holdPreset, input string req);
    @(negedge clk);
    if (!holdPreset) begin
      strobe = 1;
      expHold = expReg;
      @(negedge clk);
    end
    check(chanOut == pack(expOut), "R7 outputs unchanged on rise", chanOut, pack(expOut));
    strobe = 0;
    @(negedge clk);
    expOut = expHold;
    check(chanOut == pack(expOut), req, chanOut, pack(expOut));
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd5150));
    for (int c = 0; c < NCH; c++) begin
      expReg[c] = 0; expHold[c] = 0; expOut[c] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(chanOut == '0, "R1 reset outputs", chanOut, '0);
    check(outPin() == 1'b0, "R1 reset start out", FL'(outPin()), '0);

    // R2 forward fill
    frame(1'b1, 1'b0, -1);
    latchAndShow(1'b0, "R2 forward fill R8");

    // R3 reverse fill
    frame(1'b0, 1'b0, -1);
    latchAndShow(1'b0, "R3 reverse fill R8");

    // R6 data after fill ignored
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      dataIn = $urandom;
    end
    latchAndShow(1'b0, "R6 idle data ignored");

    // R6 restart during loading ignored, R4 timing preserved
    frame(1'b1, 1'b0, 2);
    latchAndShow(1'b0, "R6 restart ignored R4");

    // R9 strobe rise coincides with the last group load
    frame(1'b0, 1'b1, -1);
    latchAndShow(1'b1, "R9 rise with last group");
    // then a normal latch shows the full line
    latchAndShow(1'b0, "R9 full line after relatch");

    // random mix
    for (int n = 0; n < 8; n++) begin
      frame(1'($urandom), 1'b0, ($urandom % 3 == 0) ? int'($urandom % NG) : -1);
      latchAndShow(1'b0, "R4 random frame R8");
    end
    finishRun();
  end
endmodule